// File: doc/BRIEF.md
# Event Packet Timestamp Capture

This block records the system time at which a precision-time event packet crosses the start-of-frame point, on receive and on transmit. Each direction owns exactly one capture slot. A filled slot holds its 64-bit time, split into a low and a high word, and raises a valid flag. It accepts nothing further until software reads the high word, which frees the slot again.

On receive, a classifier inspects a handful of pre-extracted header fields: ethertype, a UDP flag, UDP destination port, protocol version and message type. It decides from these and the configured mode whether the frame is to be stamped. In version 1 mode, only UDP frames that carry one programmed message type are stamped. In version 2 mode, every event message is stamped, including the peer-delay messages. Such a frame can arrive either on the precision-time ethertype or over UDP. A stamped receive frame is also flagged toward the descriptor writer through a one-cycle tag. Because the slot stays locked until it is read, at most one tagged frame can be outstanding.

On transmit, software marks individual frames with a request flag. The time is latched for a marked frame when the transmit slot is free.

Top module: `ptp_stamp_latch`

## Requirements
- R1: After reset, both valid flags, all four stamp words and the descriptor tag are 0.
- R2: When a receive frame qualifies at `rx_sof`, the receive slot is free and `cfg_rx_en` is 1, the following happen in the next cycle. `rx_valid` becomes 1, `{rx_stamp_hi, rx_stamp_lo}` equals `sys_time` from the `rx_sof` cycle, and `rx_desc_ts` is 1 for exactly that one cycle.
- R3: While `rx_valid` is 1, a qualifying frame changes neither stamp word and raises no descriptor tag. This also applies when the frame arrives in the same cycle as the read.
- R4: A pulse on `rx_rd_hi` while `rx_valid` is 1 clears `rx_valid` in the next cycle, after which the next qualifying frame is captured. A pulse while the slot is empty has no effect.
- R5: Mode 2'b01 (version 1) qualifies a frame only when all of these hold: `rx_is_udp`=1, `rx_dst_port`=`cfg_udp_port`, `rx_version`=1 and `rx_msg_type`=`cfg_v1_msg`. Frames arriving by ethertype never qualify in this mode.
- R6: Mode 2'b10 (version 2) qualifies a frame only when `rx_version`=2 and `rx_msg_type` is an event type (0 through 3, including peer-delay types 2 and 3). Type 8 does not qualify.
- R7: Modes 2'b00 and 2'b11, or `cfg_rx_en`=0, qualify no frame.
- R8: A transmit frame is captured when all of these hold at `tx_sof`: `tx_req`=1, `cfg_tx_en`=1 and the transmit slot is free. Once captured, `tx_valid` is 1 in the next cycle, with the stamp equal to `sys_time` from the `tx_sof` cycle. A frame without `tx_req`, or arriving while `tx_valid` is 1, is ignored.
- R9: A pulse on `tx_rd_hi` while `tx_valid` is 1 clears `tx_valid` in the next cycle.
- R10: In version 2 mode, a frame qualifies by ethertype only when `rx_ethertype`=16'h88F7 and `cfg_etype_ts_en`=1. Otherwise it qualifies through UDP, when `rx_is_udp`=1 and `rx_dst_port`=`cfg_udp_port` (event port 319 in normal use).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_time | input | 64 | Running system time |
| cfg_rx_en | input | 1 | Receive capture enable |
| cfg_tx_en | input | 1 | Transmit capture enable |
| cfg_rx_mode | input | 2 | 00 off, 01 version 1, 10 version 2, 11 off |
| cfg_v1_msg | input | 4 | Message type captured in version 1 mode |
| cfg_udp_port | input | 16 | UDP event destination port |
| cfg_etype_ts_en | input | 1 | Allow ethertype-based match |
| rx_sof | input | 1 | Receive start-of-frame strobe, fields valid |
| rx_ethertype | input | 16 | Frame ethertype |
| rx_is_udp | input | 1 | Frame carries UDP |
| rx_dst_port | input | 16 | UDP destination port |
| rx_version | input | 4 | Protocol version field |
| rx_msg_type | input | 4 | Message type field |
| rx_rd_hi | input | 1 | Read strobe of receive high word, frees slot |
| rx_valid | output | 1 | Receive stamp waiting |
| rx_stamp_lo | output | 32 | Receive stamp low word |
| rx_stamp_hi | output | 32 | Receive stamp high word |
| rx_desc_ts | output | 1 | Descriptor tag for the stamped frame |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_req | input | 1 | Per-frame stamp request |
| tx_rd_hi | input | 1 | Read strobe of transmit high word, frees slot |
| tx_valid | output | 1 | Transmit stamp waiting |
| tx_stamp_lo | output | 32 | Transmit stamp low word |
| tx_stamp_hi | output | 32 | Transmit stamp high word |

## Verification
Every result here is one register away from its cause. The valid flag, both stamp words and the descriptor tag settle on the rising edge that samples `rx_sof` or `tx_sof`, and a read clears the flag on the edge that samples the strobe. The bench therefore drives each strobe on a falling edge and drops it on the next falling edge, checking outputs at that same point, where the one-cycle tag is still high. Lock and release cases check the stamp words over several such half-period windows, so a wrongly overwritten slot shows up as a changed value.

// File: rtl/pts_pkg.sv
package pts_pkg;
  typedef enum logic [1:0] {
    PTS_OFF  = 2'b00,
    PTS_V1   = 2'b01,
    PTS_V2   = 2'b10,
    PTS_OFF3 = 2'b11
  } pts_mode_e;

  localparam int          MSG_W      = 4;
  localparam int          PORT_W     = 16;
  localparam logic [15:0] PTP_ETYPE  = 16'h88F7;
  localparam int          EVT_LAST   = 3;
  localparam logic [3:0]  VER_ONE    = 4'd1;
  localparam logic [3:0]  VER_TWO    = 4'd2;
endpackage

// File: rtl/pts_rx_match.sv
module pts_rx_match
  import pts_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [MSG_W-1:0]  v1_msg,
  input  logic [PORT_W-1:0] udp_port,
  input  logic              etype_en,
  input  logic [15:0]       ethertype,
  input  logic              is_udp,
  input  logic [PORT_W-1:0] dst_port,
  input  logic [3:0]        version,
  input  logic [MSG_W-1:0]  msg_type,
  output logic              hit
);
  logic udp_ok, etype_ok, is_event;

  always_comb begin
    udp_ok   = is_udp && (dst_port == udp_port);
    etype_ok = etype_en && (ethertype == PTP_ETYPE);
    is_event = (int'(msg_type) <= EVT_LAST);
    unique case (pts_mode_e'(mode))
      PTS_V1:  hit = udp_ok && (version == VER_ONE) && (msg_type == v1_msg);
      PTS_V2:  hit = (udp_ok || etype_ok) && (version == VER_TWO) && is_event;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pts_slot.sv
module pts_slot #(
  parameter int TIME_W = 64,
  localparam int HALF_W = TIME_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              rel,
  input  logic [TIME_W-1:0] time_in,
  output logic              valid,
  output logic [HALF_W-1:0] stamp_lo,
  output logic [HALF_W-1:0] stamp_hi,
  output logic              took
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      stamp_lo <= '0;
      stamp_hi <= '0;
      took     <= 1'b0;
    end else begin
      took <= 1'b0;
      if (valid) begin
        if (rel) valid <= 1'b0;
      end else if (take) begin
        valid    <= 1'b1;
        stamp_lo <= time_in[HALF_W-1:0];
        stamp_hi <= time_in[TIME_W-1:HALF_W];
        took     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptp_stamp_latch.sv
module ptp_stamp_latch
  import pts_pkg::*;
#(
  parameter int TIME_W = 64,
  localparam int HALF_W = TIME_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              cfg_rx_en,
  input  logic              cfg_tx_en,
  input  logic [1:0]        cfg_rx_mode,
  input  logic [MSG_W-1:0]  cfg_v1_msg,
  input  logic [PORT_W-1:0] cfg_udp_port,
  input  logic              cfg_etype_ts_en,
  input  logic              rx_sof,
  input  logic [15:0]       rx_ethertype,
  input  logic              rx_is_udp,
  input  logic [PORT_W-1:0] rx_dst_port,
  input  logic [3:0]        rx_version,
  input  logic [MSG_W-1:0]  rx_msg_type,
  input  logic              rx_rd_hi,
  output logic              rx_valid,
  output logic [HALF_W-1:0] rx_stamp_lo,
  output logic [HALF_W-1:0] rx_stamp_hi,
  output logic              rx_desc_ts,
  input  logic              tx_sof,
  input  logic              tx_req,
  input  logic              tx_rd_hi,
  output logic              tx_valid,
  output logic [HALF_W-1:0] tx_stamp_lo,
  output logic [HALF_W-1:0] tx_stamp_hi
);
  logic rx_hit, rx_take, tx_take, tx_took_unused;

  pts_rx_match u_match (
    .mode      (cfg_rx_mode),
    .v1_msg    (cfg_v1_msg),
    .udp_port  (cfg_udp_port),
    .etype_en  (cfg_etype_ts_en),
    .ethertype (rx_ethertype),
    .is_udp    (rx_is_udp),
    .dst_port  (rx_dst_port),
    .version   (rx_version),
    .msg_type  (rx_msg_type),
    .hit       (rx_hit)
  );

  assign rx_take = rx_sof && cfg_rx_en && rx_hit;
  assign tx_take = tx_sof && tx_req && cfg_tx_en;

  pts_slot #(.TIME_W(TIME_W)) u_rx_slot (
    .clk      (clk),
    .rst      (rst),
    .take     (rx_take),
    .rel      (rx_rd_hi),
    .time_in  (sys_time),
    .valid    (rx_valid),
    .stamp_lo (rx_stamp_lo),
    .stamp_hi (rx_stamp_hi),
    .took     (rx_desc_ts)
  );

  pts_slot #(.TIME_W(TIME_W)) u_tx_slot (
    .clk      (clk),
    .rst      (rst),
    .take     (tx_take),
    .rel      (tx_rd_hi),
    .time_in  (sys_time),
    .valid    (tx_valid),
    .stamp_lo (tx_stamp_lo),
    .stamp_hi (tx_stamp_hi),
    .took     (tx_took_unused)
  );
endmodule

// File: rtl/pts_checker.sv
module pts_checker #(
  parameter int TIME_W = 64,
  localparam int HALF_W = TIME_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic [TIME_W-1:0] sys_time,
  input logic              cfg_rx_en,
  input logic              cfg_tx_en,
  input logic              rx_sof,
  input logic              rx_rd_hi,
  input logic              rx_valid,
  input logic [HALF_W-1:0] rx_stamp_lo,
  input logic [HALF_W-1:0] rx_stamp_hi,
  input logic              rx_desc_ts,
  input logic              tx_sof,
  input logic              tx_req,
  input logic              tx_rd_hi,
  input logic              tx_valid,
  input logic [HALF_W-1:0] tx_stamp_lo,
  input logic [HALF_W-1:0] tx_stamp_hi
);
  a_r2_stamp_time: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) |-> ({rx_stamp_hi, rx_stamp_lo} == $past(sys_time)) && $past(rx_sof));

  a_r2_tag_with_fill: assert property (@(posedge clk) disable iff (rst)
    rx_desc_ts |-> $rose(rx_valid));

  a_r3_locked_hold: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_rd_hi |=> rx_valid && $stable(rx_stamp_lo) && $stable(rx_stamp_hi));

  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_rd_hi |=> !rx_valid && !rx_desc_ts);

  a_r7_rx_disabled: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) |-> $past(cfg_rx_en));

  a_r8_tx_fill: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> $past(tx_sof && tx_req && cfg_tx_en)
                        && ({tx_stamp_hi, tx_stamp_lo} == $past(sys_time)));

  a_r8_tx_hold: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_rd_hi |=> tx_valid && $stable(tx_stamp_lo) && $stable(tx_stamp_hi));

  a_r9_tx_release: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_rd_hi |=> !tx_valid);
endmodule

bind ptp_stamp_latch pts_checker #(.TIME_W(TIME_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sys_time    (sys_time),
  .cfg_rx_en   (cfg_rx_en),
  .cfg_tx_en   (cfg_tx_en),
  .rx_sof      (rx_sof),
  .rx_rd_hi    (rx_rd_hi),
  .rx_valid    (rx_valid),
  .rx_stamp_lo (rx_stamp_lo),
  .rx_stamp_hi (rx_stamp_hi),
  .rx_desc_ts  (rx_desc_ts),
  .tx_sof      (tx_sof),
  .tx_req      (tx_req),
  .tx_rd_hi    (tx_rd_hi),
  .tx_valid    (tx_valid),
  .tx_stamp_lo (tx_stamp_lo),
  .tx_stamp_hi (tx_stamp_hi)
);

// File: tb/sim_ptp_stamp_latch.sv
module sim_ptp_stamp_latch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] sys_time = '0;
  logic        cfg_rx_en = 1'b0, cfg_tx_en = 1'b0, cfg_etype_ts_en = 1'b0;
  logic [1:0]  cfg_rx_mode = 2'b00;
  logic [3:0]  cfg_v1_msg = '0;
  logic [15:0] cfg_udp_port = 16'd319;
  logic        rx_sof = 1'b0, rx_is_udp = 1'b0, rx_rd_hi = 1'b0;
  logic [15:0] rx_ethertype = '0, rx_dst_port = '0;
  logic [3:0]  rx_version = '0, rx_msg_type = '0;
  logic        rx_valid, rx_desc_ts, tx_valid;
  logic [31:0] rx_stamp_lo, rx_stamp_hi, tx_stamp_lo, tx_stamp_hi;
  logic        tx_sof = 1'b0, tx_req = 1'b0, tx_rd_hi = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ptp_stamp_latch u0 (
    .clk(clk), .rst(rst), .sys_time(sys_time),
    .cfg_rx_en(cfg_rx_en), .cfg_tx_en(cfg_tx_en), .cfg_rx_mode(cfg_rx_mode),
    .cfg_v1_msg(cfg_v1_msg), .cfg_udp_port(cfg_udp_port), .cfg_etype_ts_en(cfg_etype_ts_en),
    .rx_sof(rx_sof), .rx_ethertype(rx_ethertype), .rx_is_udp(rx_is_udp),
    .rx_dst_port(rx_dst_port), .rx_version(rx_version), .rx_msg_type(rx_msg_type),
    .rx_rd_hi(rx_rd_hi), .rx_valid(rx_valid), .rx_stamp_lo(rx_stamp_lo),
    .rx_stamp_hi(rx_stamp_hi), .rx_desc_ts(rx_desc_ts),
    .tx_sof(tx_sof), .tx_req(tx_req), .tx_rd_hi(tx_rd_hi), .tx_valid(tx_valid),
    .tx_stamp_lo(tx_stamp_lo), .tx_stamp_hi(tx_stamp_hi)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  v1msg;
    logic        eten;
    logic [15:0] etype;
    logic        udp;
    logic [15:0] port;
    logic [3:0]  ver;
    logic [3:0]  msg;
    logic        want;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{2'b01, 4'd0, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd1, 4'd0, 1'b1},
    '{2'b01, 4'd0, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd1, 4'd1, 1'b0},
    '{2'b01, 4'd1, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd1, 4'd1, 1'b1},
    '{2'b01, 4'd0, 1'b0, 16'h0800, 1'b1, 16'd320, 4'd1, 4'd0, 1'b0},
    '{2'b01, 4'd0, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd1, 4'd0, 1'b0},
    '{2'b10, 4'd0, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd2, 4'd0, 1'b1},
    '{2'b10, 4'd0, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd2, 4'd2, 1'b1},
    '{2'b10, 4'd0, 1'b0, 16'h88F7, 1'b0, 16'd0,   4'd2, 4'd0, 1'b0},
    '{2'b10, 4'd0, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd2, 4'd3, 1'b1},
    '{2'b10, 4'd0, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd2, 4'd8, 1'b0},
    '{2'b10, 4'd0, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd1, 4'd0, 1'b0},
    '{2'b00, 4'd0, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd2, 4'd0, 1'b0},
    '{2'b11, 4'd0, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd2, 4'd0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic rx_frame(input vec_t v, input logic [63:0] t, input bit with_rd);
    @(negedge clk);
    rx_ethertype = v.etype; rx_is_udp = v.udp; rx_dst_port = v.port;
    rx_version = v.ver; rx_msg_type = v.msg; sys_time = t;
    rx_sof = 1'b1; rx_rd_hi = with_rd;
    @(negedge clk);
    rx_sof = 1'b0; rx_rd_hi = 1'b0;
  endtask

  task automatic rx_read();
    @(negedge clk); rx_rd_hi = 1'b1;
    @(negedge clk); rx_rd_hi = 1'b0;
  endtask

  task automatic tx_frame(input bit req, input logic [63:0] t);
    @(negedge clk); tx_req = req; tx_sof = 1'b1; sys_time = t;
    @(negedge clk); tx_sof = 1'b0; tx_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    vec_t good;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!rx_valid && !tx_valid && !rx_desc_ts, "R1 flags", {61'd0, rx_valid, tx_valid, rx_desc_ts}, 64'd0);
    chk({rx_stamp_hi, rx_stamp_lo} == 64'd0, "R1 rx stamp", {rx_stamp_hi, rx_stamp_lo}, 64'd0);
    chk({tx_stamp_hi, tx_stamp_lo} == 64'd0, "R1 tx stamp", {tx_stamp_hi, tx_stamp_lo}, 64'd0);

    // Table walk: R5 R6 R7 R10 classification, R2 capture
    cfg_rx_en = 1'b1; cfg_udp_port = 16'd319;
    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] t;
      t = 64'hA5A5_0000_0000_0100 + 64'(i) * 64'h0001_0003_0000_0011;
      cfg_rx_mode = VEC[i].mode; cfg_v1_msg = VEC[i].v1msg; cfg_etype_ts_en = VEC[i].eten;
      rx_frame(VEC[i], t, 1'b0);
      chk(rx_valid == VEC[i].want, $sformatf("R5 R6 R7 R10 vector %0d valid", i), 64'(rx_valid), 64'(VEC[i].want));
      chk(rx_desc_ts == VEC[i].want, $sformatf("R2 vector %0d tag", i), 64'(rx_desc_ts), 64'(VEC[i].want));
      if (VEC[i].want) begin
        chk({rx_stamp_hi, rx_stamp_lo} == t, $sformatf("R2 vector %0d stamp", i), {rx_stamp_hi, rx_stamp_lo}, t);
        rx_read();
        chk(!rx_valid, "R4 release after table hit", 64'(rx_valid), 64'd0);
      end
    end

    // R3 lock and R4 release
    good = VEC[5];
    cfg_rx_mode = 2'b10; cfg_etype_ts_en = 1'b1;
    rx_frame(good, 64'h1111_2222_3333_4444, 1'b0);
    @(negedge clk);
    chk(!rx_desc_ts, "R2 tag lasts one cycle", 64'(rx_desc_ts), 64'd0);
    rx_frame(good, 64'h5555_6666_7777_8888, 1'b0);
    chk({rx_stamp_hi, rx_stamp_lo} == 64'h1111_2222_3333_4444, "R3 locked stamp",
        {rx_stamp_hi, rx_stamp_lo}, 64'h1111_2222_3333_4444);
    chk(rx_valid && !rx_desc_ts, "R3 locked no tag", {62'd0, rx_valid, rx_desc_ts}, 64'd2);
    rx_frame(good, 64'h9999_0000_0000_0001, 1'b1);
    chk(!rx_valid && !rx_desc_ts, "R3 R4 frame with read not captured", {62'd0, rx_valid, rx_desc_ts}, 64'd0);
    rx_read();
    chk(!rx_valid, "R4 read on empty slot", 64'(rx_valid), 64'd0);
    rx_frame(good, 64'h0000_0000_DEAD_BEEF, 1'b0);
    chk(rx_valid && {rx_stamp_hi, rx_stamp_lo} == 64'h0000_0000_DEAD_BEEF, "R4 recapture after release",
        {rx_stamp_hi, rx_stamp_lo}, 64'h0000_0000_DEAD_BEEF);
    rx_read();

    // R7 receive disable
    cfg_rx_en = 1'b0;
    rx_frame(good, 64'h42, 1'b0);
    chk(!rx_valid, "R7 rx disabled", 64'(rx_valid), 64'd0);

    // R8 R9 transmit
    cfg_tx_en = 1'b1;
    tx_frame(1'b0, 64'h77);
    chk(!tx_valid, "R8 no request ignored", 64'(tx_valid), 64'd0);
    cfg_tx_en = 1'b0;
    tx_frame(1'b1, 64'h78);
    chk(!tx_valid, "R8 tx disabled", 64'(tx_valid), 64'd0);
    cfg_tx_en = 1'b1;
    tx_frame(1'b1, 64'hCAFE_F00D_0123_4567);
    chk(tx_valid && {tx_stamp_hi, tx_stamp_lo} == 64'hCAFE_F00D_0123_4567, "R8 tx capture",
        {tx_stamp_hi, tx_stamp_lo}, 64'hCAFE_F00D_0123_4567);
    chk(!rx_valid, "R8 rx slot untouched by tx", 64'(rx_valid), 64'd0);
    tx_frame(1'b1, 64'h0BAD);
    chk({tx_stamp_hi, tx_stamp_lo} == 64'hCAFE_F00D_0123_4567, "R8 tx locked",
        {tx_stamp_hi, tx_stamp_lo}, 64'hCAFE_F00D_0123_4567);
    @(negedge clk); tx_rd_hi = 1'b1;
    @(negedge clk); tx_rd_hi = 1'b0;
    chk(!tx_valid, "R9 tx release", 64'(tx_valid), 64'd0);
    tx_frame(1'b1, 64'h0000_0001_0000_0002);
    chk(tx_valid && {tx_stamp_hi, tx_stamp_lo} == 64'h0000_0001_0000_0002, "R9 tx recapture",
        {tx_stamp_hi, tx_stamp_lo}, 64'h0000_0001_0000_0002);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule